// File: doc/BRIEF.md
# Configurable Product-Term AND Plane

This block is the AND plane of a small programmable-logic fabric. A bundle of routed input signals is turned into twice as many array lines, each input giving a true and an inverted copy. Every product term has a connection mask over all lines, and it outputs the AND of the lines its mask selects. The terms fall into two groups. Logic terms are handed to the macrocells in fixed clusters, one cluster per macrocell. Three control terms feed the shared clock, initialization and output-enable nets.

The connection masks and the two inversion bits are written through a serial chain, one bit per clock while a shift enable is high. A load strobe then moves the whole chain into the active configuration in one cycle, so the terms never decode a half-written pattern. From the routed inputs to the product terms the path is purely combinational. All outputs return to the global routing network, and the array has no internal feedback.

Top module: `pta_and_array`

## Requirements
- R1: After reset, every connection bit and both inversion bits are 0, so every logic term and all three control outputs read 1 until the first load.
- R2: Line l for l below 36 is route_in[l], and line l for l from 36 to 71 is the inverse of route_in[l-36].
- R3: A term outputs 1 exactly when every line selected by its mask is 1. A term with an empty mask outputs 1.
- R4: A term whose mask selects both the true and the inverted line of the same input always outputs 0.
- R5: Logic term t (0 to 79) appears at cluster_pt bit t, so member k of cluster c is bit 5*c+k, with cluster 0 starting at term 0.
- R6: Term 80 drives pt_clk and term 81 drives pt_init. Each is inverted when its inversion bit is 1. Term 82 drives pt_oe and is never inverted.
- R7: While cfg_shift_en is high, each clock moves chain bit j to bit j+1 and puts cfg_sdi at bit 0. Chain bit t*72+l is the mask bit of term t for line l. Bit 5976 inverts the clock term and bit 5977 inverts the initialization term.
- R8: The outputs depend only on route_in and the active configuration. Shifting without a load strobe has no effect on any output.
- R9: A change on route_in reaches the term outputs without waiting for a clock edge.
- R10: A load strobe copies the chain as it stood before that clock edge, even if a shift happens on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_shift_en | input | 1 | Shift the configuration chain by one bit |
| cfg_sdi | input | 1 | Serial configuration data |
| cfg_load | input | 1 | Copy the chain into the active configuration |
| route_in | input | 36 | Signals from the global routing network |
| cluster_pt | output | 80 | Logic terms, 16 clusters of 5 |
| pt_clk | output | 1 | Shared clock term, optionally inverted |
| pt_init | output | 1 | Shared initialization term, optionally inverted |
| pt_oe | output | 1 | Shared output-enable term |

## Verification
A one-line-per-term configuration is driven with all-zero, all-one, walking and random inputs. This shows whether each term follows exactly its own true or inverted line and whether it lands at the right cluster position. A sparse random configuration that includes an empty term, a contradictory term and matching masks on the output-enable term and a logic term separates correct AND semantics from stuck or inverted terms. Inversion settings are varied between loads. Shifting without a strobe and shifting on the same edge as a strobe show whether a partially shifted chain can leak into the active configuration, and whether the strobe takes the chain from before or after that edge's shift.

// File: rtl/pta_pkg.sv
`timescale 1ns/1ps
package pta_pkg;
  // positions of the shared control terms after the logic terms
  typedef enum logic [1:0] {
    CTRL_CLK  = 2'd0,
    CTRL_INIT = 2'd1,
    CTRL_OE   = 2'd2
  } pta_ctrl_e;

  localparam int unsigned PTA_N_CTRL = 3;
  localparam int unsigned PTA_N_INV  = 2;

  function automatic int unsigned pta_lines(input int unsigned n_in);
    return 2 * n_in;
  endfunction
endpackage

// File: rtl/pta_line_expand.sv
`timescale 1ns/1ps
module pta_line_expand #(
  parameter int unsigned N_IN = 36
) (
  input  logic [N_IN-1:0]   route_in,
  output logic [2*N_IN-1:0] lines
);
  // low half true copies, high half inverted copies
  genvar i;
  generate
    for (i = 0; i < N_IN; i++) begin : g_line
      assign lines[i]        = route_in[i];
      assign lines[N_IN + i] = ~route_in[i];
    end
  endgenerate
endmodule

// File: rtl/pta_term.sv
`timescale 1ns/1ps
module pta_term #(
  parameter int unsigned N_LINE = 72
) (
  input  logic [N_LINE-1:0] lines,
  input  logic [N_LINE-1:0] mask,
  output logic              term
);
  // unselected lines are forced high, so an empty mask gives 1
  logic [N_LINE-1:0] pass;
  assign pass = lines | ~mask;
  assign term = &pass;
endmodule

// File: rtl/pta_cfg_store.sv
`timescale 1ns/1ps
module pta_cfg_store #(
  parameter int unsigned N_PT   = 83,
  parameter int unsigned N_LINE = 72,
  parameter int unsigned N_INV  = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          shift_en,
  input  logic                          sdi,
  input  logic                          load,
  output logic [N_PT-1:0][N_LINE-1:0]   act_mask,
  output logic [N_INV-1:0]              act_inv
);
  localparam int unsigned N_MASK = N_PT * N_LINE;
  localparam int unsigned N_BITS = N_MASK + N_INV;

  logic [N_BITS-1:0] chain_q, chain_d;
  logic [N_BITS-1:0] act_q, act_d;

  always_comb begin
    chain_d = chain_q;
    if (shift_en) chain_d = {chain_q[N_BITS-2:0], sdi};
  end

  always_comb begin
    act_d = act_q;
    if (load) act_d = chain_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      act_q   <= '0;
    end else begin
      chain_q <= chain_d;
      act_q   <= act_d;
    end
  end

  assign act_mask = act_q[N_MASK-1:0];
  assign act_inv  = act_q[N_BITS-1:N_MASK];
endmodule

// File: rtl/pta_and_array.sv
`timescale 1ns/1ps
module pta_and_array #(
  parameter int unsigned N_IN       = 36,
  parameter int unsigned N_CLUSTER  = 16,
  parameter int unsigned CLUSTER_SZ = 5
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  cfg_shift_en,
  input  logic                                  cfg_sdi,
  input  logic                                  cfg_load,
  input  logic [N_IN-1:0]                       route_in,
  output logic [N_CLUSTER-1:0][CLUSTER_SZ-1:0]  cluster_pt,
  output logic                                  pt_clk,
  output logic                                  pt_init,
  output logic                                  pt_oe
);
  import pta_pkg::*;

  localparam int unsigned N_LINE  = pta_lines(N_IN);
  localparam int unsigned N_LOGIC = N_CLUSTER * CLUSTER_SZ;
  localparam int unsigned N_PT    = N_LOGIC + PTA_N_CTRL;

  logic [N_LINE-1:0]               lines;
  logic [N_PT-1:0][N_LINE-1:0]     act_mask;
  logic [PTA_N_INV-1:0]            act_inv;
  logic [N_PT-1:0]                 term_raw;
  logic [PTA_N_CTRL-1:0]           ctrl_raw;
  logic [PTA_N_CTRL-1:0]           ctrl_out;

  pta_line_expand #(.N_IN(N_IN)) u_expand (
    .route_in (route_in),
    .lines    (lines)
  );

  pta_cfg_store #(.N_PT(N_PT), .N_LINE(N_LINE), .N_INV(PTA_N_INV)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (cfg_shift_en),
    .sdi      (cfg_sdi),
    .load     (cfg_load),
    .act_mask (act_mask),
    .act_inv  (act_inv)
  );

  genvar t, c, k, q;
  generate
    for (t = 0; t < N_PT; t++) begin : g_term
      pta_term #(.N_LINE(N_LINE)) u_term (
        .lines (lines),
        .mask  (act_mask[t]),
        .term  (term_raw[t])
      );
    end

    for (c = 0; c < N_CLUSTER; c++) begin : g_cluster
      for (k = 0; k < CLUSTER_SZ; k++) begin : g_member
        assign cluster_pt[c][k] = term_raw[c*CLUSTER_SZ + k];
      end
    end

    for (q = 0; q < PTA_N_CTRL; q++) begin : g_ctrl
      assign ctrl_raw[q] = term_raw[N_LOGIC + q];
      if (q < PTA_N_INV) begin : g_inv
        assign ctrl_out[q] = ctrl_raw[q] ^ act_inv[q];
      end else begin : g_plain
        assign ctrl_out[q] = ctrl_raw[q];
      end
    end
  endgenerate

  assign pt_clk  = ctrl_out[CTRL_CLK];
  assign pt_init = ctrl_out[CTRL_INIT];
  assign pt_oe   = ctrl_out[CTRL_OE];
endmodule

// File: rtl/pta_and_array_chk.sv
`timescale 1ns/1ps
module pta_and_array_chk #(
  parameter int unsigned N_IN    = 36,
  parameter int unsigned N_LOGIC = 80,
  parameter int unsigned N_PT    = 83
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          cfg_load,
  input logic [N_IN-1:0]               route_in,
  input logic [N_LOGIC-1:0]            logic_flat,
  input logic                          pt_clk,
  input logic                          pt_init,
  input logic                          pt_oe,
  input logic [N_PT-1:0][2*N_IN-1:0]   act_mask,
  input logic [1:0]                    act_inv
);
  logic seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else if (cfg_load) seen_q <= 1'b1;
  end

  p_reset_ones_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> ((&logic_flat) && pt_clk && pt_init && pt_oe));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_load ##1 $stable(route_in)) |->
      ($stable(logic_flat) && $stable(pt_clk) && $stable(pt_init) && $stable(pt_oe)));

  p_oe_plain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mask[N_PT-1] == act_mask[0]) |-> (pt_oe == logic_flat[0]));

  p_clk_inv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mask[N_LOGIC] == act_mask[0]) |-> (pt_clk == (logic_flat[0] ^ act_inv[0])));

  p_init_inv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mask[N_LOGIC+1] == act_mask[0]) |-> (pt_init == (logic_flat[0] ^ act_inv[1])));

  genvar t;
  generate
    for (t = 0; t < N_LOGIC; t++) begin : g_lt
      p_contra_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(act_mask[t][N_IN-1:0] & act_mask[t][2*N_IN-1:N_IN])) |-> !logic_flat[t]);
      p_empty_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (act_mask[t] == '0) |-> logic_flat[t]);
    end
  endgenerate
endmodule

bind pta_and_array pta_and_array_chk #(
  .N_IN    (N_IN),
  .N_LOGIC (N_LOGIC),
  .N_PT    (N_PT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_load   (cfg_load),
  .route_in   (route_in),
  .logic_flat (cluster_pt),
  .pt_clk     (pt_clk),
  .pt_init    (pt_init),
  .pt_oe      (pt_oe),
  .act_mask   (act_mask),
  .act_inv    (act_inv)
);

// File: tb/test_pta_and_array.sv
`timescale 1ns/1ps
module test_pta_and_array;
  localparam int NI  = 36;
  localparam int NL  = 72;
  localparam int NPT = 83;
  localparam int NB  = NPT*NL + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_shift_en = 1'b0, cfg_sdi = 1'b0, cfg_load = 1'b0;
  logic [NI-1:0] route_in = '0;
  logic [15:0][4:0] cluster_pt;
  logic pt_clk, pt_init, pt_oe;

  always #4 clk = ~clk;

  pta_and_array i_pta_and_array (
    .clk(clk), .rst_n(rst_n), .cfg_shift_en(cfg_shift_en), .cfg_sdi(cfg_sdi),
    .cfg_load(cfg_load), .route_in(route_in), .cluster_pt(cluster_pt),
    .pt_clk(pt_clk), .pt_init(pt_init), .pt_oe(pt_oe)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [NB-1:0] sh_m = '0, act_m = '0, img;
  logic [NPT-1:0] exp_q[$];
  string tag_q[$];

  // expected outputs from the requirements: bit 80 clock, 81 init, 82 oe
  function automatic logic [NPT-1:0] model(input logic [NI-1:0] v);
    logic [NPT-1:0] r;
    for (int t = 0; t < NPT; t++) begin
      r[t] = 1'b1;
      for (int l = 0; l < NL; l++) begin
        logic ln;
        ln = (l < NI) ? v[l] : ~v[l-NI];
        if (act_m[t*NL + l] && !ln) r[t] = 1'b0;
      end
    end
    if (act_m[NPT*NL])     r[80] = ~r[80];
    if (act_m[NPT*NL + 1]) r[81] = ~r[81];
    return r;
  endfunction

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [NPT-1:0] e, got;
      string tg;
      e = exp_q.pop_front();
      tg = tag_q.pop_front();
      got = {pt_oe, pt_init, pt_clk, cluster_pt};
      n_tests++;
      if (got !== e) begin
        n_fail++;
        $display("FAIL %s got %h expected %h", tg, got, e);
      end
    end
  end

  task automatic probe(input logic [NI-1:0] v, input string tg);
    route_in = v;
    exp_q.push_back(model(v));
    tag_q.push_back(tg);
    @(posedge clk); #1;
  endtask

  task automatic shift_bit(input logic b, input logic ld);
    cfg_sdi = b; cfg_shift_en = 1'b1; cfg_load = ld;
    @(posedge clk);
    if (ld) act_m = sh_m;
    sh_m = {sh_m[NB-2:0], b};
    #1; cfg_shift_en = 1'b0; cfg_load = 1'b0;
  endtask

  task automatic pulse_load();
    cfg_load = 1'b1;
    @(posedge clk);
    act_m = sh_m;
    #1; cfg_load = 1'b0;
  endtask

  task automatic load_cfg(input logic [NB-1:0] im);
    for (int j = NB-1; j >= 0; j--) shift_bit(im[j], 1'b0);
    pulse_load();
  endtask

  function automatic logic [NI-1:0] rnd36();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    #(200000*8);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 reset state, all terms high
    probe('0, "R1 reset");
    probe('1, "R1 reset");
    probe(rnd36(), "R1 reset");
    // R8 shifting without a strobe leaves outputs alone
    for (int i = 0; i < 40; i++) shift_bit($urandom_range(0,1), 1'b0);
    probe(rnd36(), "R8 shift no load");

    // one line per term: R2 R5 R7 R9
    img = '0;
    for (int t = 0; t < NPT; t++) img[t*NL + (t % NL)] = 1'b1;
    img[NPT*NL] = 1'b1;
    load_cfg(img);
    probe('0, "R2 all zero");
    probe('1, "R2 all one");
    for (int i = 0; i < NI; i += 7) probe(36'd1 << i, "R5 walking one");
    for (int i = 0; i < 6; i++) probe(rnd36(), "R9 random");
    probe(36'h0000000FF, "R6 clk inverted");
    for (int i = 0; i < 50; i++) shift_bit($urandom_range(0,1), 1'b0);
    probe(rnd36(), "R8 shift no load");
    probe('1, "R8 shift no load");

    // sparse random masks with empty and contradictory terms: R3 R4
    img = '0;
    for (int t = 0; t < NPT; t++)
      for (int n = 0; n < 3; n++) img[t*NL + $urandom_range(0, NL-1)] = 1'b1;
    img[10*NL +: NL] = '0;
    img[7*NL +: NL] = '0;
    img[7*NL + 3] = 1'b1;
    img[7*NL + 39] = 1'b1;
    img[82*NL +: NL] = img[0 +: NL];
    img[NPT*NL] = 1'b1;
    img[NPT*NL + 1] = 1'b1;
    load_cfg(img);
    for (int i = 0; i < 6; i++) probe(rnd36(), "R3 sparse AND");
    probe('1, "R4 contradiction");
    probe('0, "R4 contradiction");

    // strobe on the same edge as a shift takes the old chain: R10
    shift_bit(1'b1, 1'b1);
    probe(rnd36(), "R10 load with shift");
    probe('1, "R10 load with shift");
    pulse_load();
    probe(rnd36(), "R7 chain order");
    probe('0, "R7 chain order");

    // control terms on input 0 with init inverted only: R6
    img = '0;
    img[80*NL] = 1'b1;
    img[81*NL] = 1'b1;
    img[82*NL] = 1'b1;
    img[NPT*NL + 1] = 1'b1;
    load_cfg(img);
    probe(36'h0, "R6 control low");
    probe(36'h1, "R6 control high");

    // reset mid-run returns to cleared configuration: R1
    rst_n = 1'b0;
    sh_m = '0; act_m = '0;
    @(posedge clk); #1 rst_n = 1'b1;
    @(posedge clk); #1;
    probe(36'h1, "R1 reset again");
    probe(rnd36(), "R1 reset again");

    @(posedge clk); #1;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule